// File: doc/BRIEF.md
# Keyed Write-Protection Gate for a Byte-Wide Nonvolatile Memory

This block sits between a host write port and the write path of a byte-wide nonvolatile array. It observes every accepted write cycle (address plus byte) and recognises two fixed keyed command sequences. A three-write unlock key turns protection on if it was off and opens one page-load window. A six-write clear key turns protection off. While protection is on and no window is open, ordinary data writes are refused. Writes that form part of a command key are never forwarded to the array, whether or not protection is on.

The page window stays open until the page-load controller pulses `page_done`. Within that window every write is treated as data and the key detector is paused. The protection flag lives in a plain register. Its power-on value comes from the `PROT_INIT` parameter and stands in for a nonvolatile bit. A write that breaks a key part-way returns the detector to its idle state. That write is then judged as an ordinary data write.

Top module: `wp_key_gate`

## Requirements
- R1: After reset, `prot_on` equals `PROT_INIT` (default 0) and `window_open` is 0.
- R2: With `prot_on` = 0, a write that is not the next key step has `wr_permit` = 1 in the same cycle.
- R3: With `prot_on` = 1 and `window_open` = 0, a write that is not a key step has `wr_permit` = 0.
- R4: A write matching the expected key step has `wr_permit` = 0. The steps are: idle expects 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 or 0x80 at 0x5555. After 0x80 the steps are 0xAA at 0x5555, 0x55 at 0x2AAA, then 0x20 at 0x5555.
- R5: The cycle after the 0xA0 step completes, `prot_on` = 1 and `window_open` = 1.
- R6: While `window_open` = 1, every write has `wr_permit` = 1, including writes whose address and byte form a key step, and no key is tracked.
- R7: A `page_done` pulse while the window is open closes it from the next cycle. A write in the same cycle as that pulse is still permitted.
- R8: The cycle after the final 0x20 step of the clear key, `prot_on` = 0 and `window_open` = 0.
- R9: A write that does not match the expected step returns the detector to idle. A following 0xA0 at 0x5555 is then not a key step.
- R10: If the 0xA0 unlock step falls in the same cycle as `page_done`, the window still opens.
- R11: With `wr_valid` = 0, `wr_permit` = 0 and neither the flags nor the key progress change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | An accepted write cycle is present |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write byte |
| page_done | input | 1 | Page load finished (closes the window) |
| wr_permit | output | 1 | Forward this write to the array |
| prot_on | output | 1 | Protection flag |
| window_open | output | 1 | Unlocked page window is open |

## Verification
Two collisions matter here. The first is a window-closing `page_done` that arrives in the same cycle as a data write inside the window. The second is `page_done` arriving in the same cycle as the final 0xA0 unlock step. Directed cases set up both collisions exactly. Random bursts of keys, broken keys, page loads and stray `page_done` pulses also hit them by chance. In each cycle a bench reference model judges the same-cycle `wr_permit` and the next-cycle `window_open` for these cases.

// File: rtl/wp_key_gate.sv
module wp_key_gate #(
  parameter int          ADDR_W    = 15,
  parameter logic [14:0] KEY_ADDR1 = 15'h5555,
  parameter logic [14:0] KEY_ADDR2 = 15'h2AAA,
  parameter bit          PROT_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              page_done,
  output logic              wr_permit,
  output logic              prot_on,
  output logic              window_open
);

  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(KEY_ADDR1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(KEY_ADDR2);

  typedef enum logic [2:0] {K_IDLE, K_S1, K_S2, K_C3, K_C4, K_C5} kst_t;

  kst_t st_q, st_d;
  logic prot_q, win_q;
  logic at1, at2, step_ok, live, is_key, unlock_done, clear_done;

  assign at1  = (wr_addr == A1);
  assign at2  = (wr_addr == A2);
  assign live = wr_valid && !win_q;

  always_comb begin
    case (st_q)
      K_IDLE:  step_ok = at1 && wr_data == 8'hAA;
      K_S1:    step_ok = at2 && wr_data == 8'h55;
      K_S2:    step_ok = at1 && (wr_data == 8'hA0 || wr_data == 8'h80);
      K_C3:    step_ok = at1 && wr_data == 8'hAA;
      K_C4:    step_ok = at2 && wr_data == 8'h55;
      K_C5:    step_ok = at1 && wr_data == 8'h20;
      default: step_ok = 1'b0;
    endcase
  end

  assign is_key      = live && step_ok;
  assign unlock_done = is_key && st_q == K_S2 && wr_data == 8'hA0;
  assign clear_done  = is_key && st_q == K_C5;

  always_comb begin
    st_d = st_q;
    if (live) begin
      if (!step_ok) st_d = K_IDLE;
      else begin
        case (st_q)
          K_IDLE:  st_d = K_S1;
          K_S1:    st_d = K_S2;
          K_S2:    st_d = (wr_data == 8'hA0) ? K_IDLE : K_C3;
          K_C3:    st_d = K_C4;
          K_C4:    st_d = K_C5;
          default: st_d = K_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= K_IDLE;
      prot_q <= PROT_INIT;
      win_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (unlock_done)     prot_q <= 1'b1;
      else if (clear_done) prot_q <= 1'b0;
      if (unlock_done)     win_q <= 1'b1;
      else if (page_done)  win_q <= 1'b0;
    end
  end

  assign wr_permit   = wr_valid && !is_key && (win_q || !prot_q);
  assign prot_on     = prot_q;
  assign window_open = win_q;

  AST_UNLOCK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_done |=> (prot_q && win_q)); // R5
  AST_UNLOCK_BEATS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_done && page_done) |=> win_q); // R10
  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && page_done) |=> !win_q); // R7
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_done |=> (!prot_q && !win_q)); // R8
  AST_WINDOW_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && wr_valid) |-> wr_permit); // R6
  AST_BREAK_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !step_ok) |=> st_q == K_IDLE); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !page_done) |=> ($stable(prot_q) && $stable(win_q) && $stable(st_q))); // R11
  AST_IDLE_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> !wr_permit); // R11

endmodule

// File: tb/test_wp_key_gate.sv
module test_wp_key_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, page_done = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic wr_permit, prot_on, window_open;

  int n_chk = 0, n_fail = 0;
  int m_st = 0;
  bit m_prot = 1'b0, m_win = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wp_key_gate i_wp_key_gate (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .page_done(page_done), .wr_permit(wr_permit),
    .prot_on(prot_on), .window_open(window_open)
  );

  function automatic bit key_match(int st, logic [14:0] a, logic [7:0] d);
    case (st)
      0: return a == 15'h5555 && d == 8'hAA;
      1: return a == 15'h2AAA && d == 8'h55;
      2: return a == 15'h5555 && (d == 8'hA0 || d == 8'h80);
      3: return a == 15'h5555 && d == 8'hAA;
      4: return a == 15'h2AAA && d == 8'h55;
      5: return a == 15'h5555 && d == 8'h20;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b exp %0b", tag, what, got, exp);
    end
  endtask

  task automatic cyc(bit v, logic [14:0] a, logic [7:0] d, bit pd, string tag);
    bit key, unl, clr, exp_p;
    wr_valid = v; wr_addr = a; wr_data = d; page_done = pd;
    #2;
    key   = v && !m_win && key_match(m_st, a, d);
    exp_p = v && !key && (m_win || !m_prot);
    chk(tag, "wr_permit", wr_permit, exp_p);
    chk(tag, "prot_on", prot_on, m_prot);
    chk(tag, "window_open", window_open, m_win);
    @(posedge clk);
    unl = key && m_st == 2 && d == 8'hA0;
    clr = key && m_st == 5;
    if (v && !m_win) begin
      if (!key) m_st = 0;
      else if (m_st == 2) m_st = (d == 8'hA0) ? 0 : 3;
      else if (m_st == 5) m_st = 0;
      else m_st = m_st + 1;
    end
    if (unl) m_prot = 1'b1; else if (clr) m_prot = 1'b0;
    if (unl) m_win = 1'b1; else if (pd) m_win = 1'b0;
    @(negedge clk);
  endtask

  function automatic string auto_tag(bit v, logic [14:0] a, logic [7:0] d);
    if (!v) return "R11";
    if (m_win) return "R6";
    if (key_match(m_st, a, d)) return "R4";
    if (m_prot) return "R3";
    return "R2";
  endfunction

  task automatic rnd(bit v, logic [14:0] a, logic [7:0] d, bit pd);
    cyc(v, a, d, pd, auto_tag(v, a, d));
  endtask

  task automatic unlock_seq(bit pd_last);
    rnd(1, 15'h5555, 8'hAA, 0);
    rnd(1, 15'h2AAA, 8'h55, 0);
    rnd(1, 15'h5555, 8'hA0, pd_last);
  endtask

  task automatic clear_seq();
    rnd(1, 15'h5555, 8'hAA, 0); rnd(1, 15'h2AAA, 8'h55, 0);
    rnd(1, 15'h5555, 8'h80, 0); rnd(1, 15'h5555, 8'hAA, 0);
    rnd(1, 15'h2AAA, 8'h55, 0); rnd(1, 15'h5555, 8'h20, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "prot_on", prot_on, 1'b0);
    chk("R1", "window_open", window_open, 1'b0);
    chk("R1", "wr_permit", wr_permit, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cyc(1, 15'h0100, 8'h3C, 0, "R2");
    cyc(0, 15'h5555, 8'hAA, 0, "R11");
    cyc(1, 15'h5555, 8'hAA, 0, "R4");
    cyc(0, 15'h0000, 8'h00, 0, "R11");
    cyc(1, 15'h2AAA, 8'h55, 0, "R4");
    cyc(1, 15'h5555, 8'hA0, 0, "R4");
    cyc(1, 15'h5555, 8'hAA, 0, "R5");
    cyc(1, 15'h1234, 8'h77, 0, "R6");
    cyc(1, 15'h0200, 8'h11, 1, "R7");
    cyc(1, 15'h0201, 8'h22, 0, "R3");
    cyc(1, 15'h5555, 8'hAA, 0, "R4");
    cyc(1, 15'h2AAA, 8'h55, 0, "R4");
    cyc(1, 15'h0040, 8'h12, 0, "R9");
    cyc(1, 15'h5555, 8'hA0, 0, "R9");
    cyc(0, 15'h0000, 8'h00, 0, "R9");
    cyc(1, 15'h5555, 8'hAA, 0, "R4");
    cyc(1, 15'h2AAA, 8'h55, 0, "R4");
    cyc(1, 15'h5555, 8'hA0, 1, "R10");
    cyc(1, 15'h4000, 8'h99, 0, "R10");
    cyc(0, 15'h0000, 8'h00, 1, "R7");
    cyc(1, 15'h4001, 8'h98, 0, "R7");
    clear_seq();
    cyc(0, 15'h0000, 8'h00, 0, "R8");
    cyc(1, 15'h0300, 8'h5A, 0, "R8");

    for (int b = 0; b < 600; b++) begin
      int kind = $urandom_range(0, 5);
      case (kind)
        0: begin
          unlock_seq($urandom_range(0, 3) == 0);
          for (int k = 0; k < $urandom_range(1, 6); k++)
            rnd(1, 15'($urandom), 8'($urandom), 0);
          rnd($urandom_range(0, 1), 15'($urandom), 8'($urandom), 1);
        end
        1: clear_seq();
        2: for (int k = 0; k < $urandom_range(1, 4); k++)
             rnd(1, 15'($urandom), 8'($urandom), $urandom_range(0, 9) == 0);
        3: begin
          rnd(1, 15'h5555, 8'hAA, 0);
          if ($urandom_range(0, 1)) rnd(1, 15'h2AAA, 8'h55, 0);
          rnd(1, 15'($urandom_range(0, 3) == 0 ? 15'h5555 : 15'($urandom)), 8'($urandom), 0);
          rnd(1, 15'h5555, 8'hA0, 0);
        end
        4: for (int k = 0; k < $urandom_range(1, 3); k++)
             rnd(0, 15'($urandom), 8'($urandom), $urandom_range(0, 4) == 0);
        default: begin
          rnd(1, 15'h5555, 8'hAA, 0);
          rnd(0, 15'h0000, 8'h00, 0);
          rnd(1, 15'h2AAA, 8'h55, 0);
          rnd(1, 15'h5555, ($urandom_range(0, 1) ? 8'hA0 : 8'h80), $urandom_range(0, 1));
        end
      endcase
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule